// File: doc/BRIEF.md
# Repeater Port Priority Arbiter

This block decides which of seven repeater ports owns the current packet. Each port reports receive activity and collision activity. A two-bit repeater-state input says what is being arbitrated. In the idle state the block looks for any port that is receiving or colliding. In the transmit-collision state it looks only for ports that are colliding. In every other state nothing is arbitrated.

Priority is fixed: port 1 wins over port 2, and so on down to port 7. A chain-enable input feeds the top of the priority chain, and a chain-pass output leaves its bottom. Several instances can therefore be daisy-chained. The first instance has its chain-enable tied high, and each chain-pass output drives the chain-enable of the next instance. A stand-alone instance simply ties chain-enable high.

The chosen port is captured in a register and presented as a 3-bit index together with a local-winner flag.

Top module: `port_arbiter`

## Requirements
- R1: Port k maps to bit k-1 of the activity vectors. Among requesting ports, the lowest-numbered one wins and is reported as index k (1..7).
- R2: With repState equal to 2'b00 (idle), a port requests when its receive bit or its collision bit is high.
- R3: With repState equal to 2'b01 (transmit collision), a port requests only when its collision bit is high. Receive activity is ignored, and with no collision the index becomes 0.
- R4: While chainIn is low, no local port can win: the next index is 0, and chainOut is low.
- R5: In both arbitration states, chainOut is high in the same cycle exactly when chainIn is high and no local port is requesting.
- R6: With repState equal to 2'b10 or 2'b11, chainOut follows chainIn, and winIdx and winValid keep their values.
- R7: In an arbitration state, the index is registered on each rising clock edge, so it appears one cycle after the inputs. winValid is high exactly when winIdx is nonzero, and index 0 means there is no local winner.
- R8: While rstN is low, winIdx is 0 and winValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| repState | input | 2 | Repeater state: 00 idle, 01 transmit collision, 10/11 other |
| rxAct | input | 7 | Receive activity, bit 0 = port 1 |
| colAct | input | 7 | Collision activity, bit 0 = port 1 |
| chainIn | input | 1 | Chain enable into the top of the priority chain |
| chainOut | output | 1 | Chain pass out of the bottom of the priority chain |
| winIdx | output | 3 | Registered winning port, 0 = no local winner |
| winValid | output | 1 | Local port holds the win |

## Verification
The bench sets the highest and the lowest ports active at the same time. A reversed priority encoder would report port 7 instead of port 1. It drives receive activity without collisions in the transmit-collision state; a design that forgot to mask receive there would name a winner and drop chainOut. It lowers chainIn while ports request, which catches a design that lets a local port win anyway or passes the chain on. It also steps through the non-arbitration states with fresh activity, which exposes a winner register that keeps updating instead of holding.

// File: rtl/port_arbiter_pkg.sv
package port_arbiter_pkg;
  localparam int NumPorts = 7;
  localparam int IdxW = $clog2(NumPorts + 1);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_XMITCOL = 2'b01,
    ST_ACTIVE  = 2'b10,
    ST_OTHER   = 2'b11
  } repStateT;

  typedef struct packed {
    logic arbOn;  // an arbitration state is active
    logic useRx;  // receive activity counts as a request
  } arbStrobeT;
endpackage

// File: rtl/port_arbiter_ctrl.sv
module port_arbiter_ctrl
  import port_arbiter_pkg::*;
(
  input  logic [1:0] repState,
  output arbStrobeT  strobe
);
  always_comb begin
    strobe = '0;
    case (repStateT'(repState))
      ST_IDLE: begin
        strobe.arbOn = 1'b1;
        strobe.useRx = 1'b1;
      end
      ST_XMITCOL: strobe.arbOn = 1'b1;
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/port_arbiter_dp.sv
module port_arbiter_dp
  import port_arbiter_pkg::*;
#(
  parameter int Ports = NumPorts,
  localparam int IW = $clog2(Ports + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobeT        strobe,
  input  logic [Ports-1:0] rxAct,
  input  logic [Ports-1:0] colAct,
  input  logic             chainIn,
  output logic             chainOut,
  output logic [IW-1:0]    winIdx,
  output logic             winValid
);
  logic [Ports-1:0] reqVec;
  logic [Ports:0]   grantPath;  // grantPath[i]: no higher port requested
  logic [IW-1:0]    pickIdx;

  assign reqVec = strobe.arbOn ? (colAct | (strobe.useRx ? rxAct : '0)) : '0;

  assign grantPath[0] = chainIn;
  for (genvar p = 0; p < Ports; p++) begin : g_chain
    assign grantPath[p+1] = grantPath[p] & ~reqVec[p];
  end
  assign chainOut = grantPath[Ports];

  always_comb begin
    pickIdx = '0;
    for (int p = Ports - 1; p >= 0; p--) begin
      if (grantPath[p] && reqVec[p]) pickIdx = IW'(p + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winIdx   <= '0;
      winValid <= 1'b0;
    end else if (strobe.arbOn) begin
      winIdx   <= pickIdx;
      winValid <= (pickIdx != '0);
    end
  end
endmodule

// File: rtl/port_arbiter.sv
module port_arbiter
  import port_arbiter_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          repState,
  input  logic [NumPorts-1:0] rxAct,
  input  logic [NumPorts-1:0] colAct,
  input  logic                chainIn,
  output logic                chainOut,
  output logic [IdxW-1:0]     winIdx,
  output logic                winValid
);
  arbStrobeT strobe;

  port_arbiter_ctrl u_ctrl (
    .repState(repState),
    .strobe  (strobe)
  );

  port_arbiter_dp #(.Ports(NumPorts)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxAct   (rxAct),
    .colAct  (colAct),
    .chainIn (chainIn),
    .chainOut(chainOut),
    .winIdx  (winIdx),
    .winValid(winValid)
  );
endmodule

// File: rtl/port_arbiter_chk.sv
module port_arbiter_chk
  import port_arbiter_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          repState,
  input logic [NumPorts-1:0] rxAct,
  input logic [NumPorts-1:0] colAct,
  input logic                chainIn,
  input logic                chainOut,
  input logic [IdxW-1:0]     winIdx,
  input logic                winValid
);
  logic inIdle, inXcol, inArb;
  assign inIdle = (repState == 2'b00);
  assign inXcol = (repState == 2'b01);
  assign inArb  = inIdle | inXcol;

  assert_top_port_wins_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && chainIn && (rxAct[0] || colAct[0])) |=> (winIdx == 3'd1));

  assert_idle_any_activity_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && chainIn && ((rxAct | colAct) != '0)) |=> winValid);

  assert_rx_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inXcol && colAct == '0) |=> (winIdx == '0));

  assert_chain_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inArb && !chainIn) |=> (winIdx == '0));

  assert_chain_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !chainIn |-> !chainOut);

  assert_pass_when_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && chainIn && (rxAct | colAct) == '0) |-> chainOut);

  assert_hold_outside_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inArb |=> ($stable(winIdx) && $stable(winValid)));

  assert_mirror_outside_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inArb |-> (chainOut == chainIn));

  assert_flag_matches_R7: assert property (@(posedge clk) disable iff (!rstN)
    winValid == (winIdx != '0));
endmodule

bind port_arbiter port_arbiter_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .repState(repState),
  .rxAct   (rxAct),
  .colAct  (colAct),
  .chainIn (chainIn),
  .chainOut(chainOut),
  .winIdx  (winIdx),
  .winValid(winValid)
);

// File: tb/port_arbiter_bench.sv
module port_arbiter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] repState = 2'b00;
  logic [6:0] rxAct = '0;
  logic [6:0] colAct = '0;
  logic       chainIn = 1'b1;
  logic       chainOut;
  logic [2:0] winIdx;
  logic       winValid;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  port_arbiter u_port_arbiter (
    .clk(clk), .rstN(rstN), .repState(repState), .rxAct(rxAct),
    .colAct(colAct), .chainIn(chainIn), .chainOut(chainOut),
    .winIdx(winIdx), .winValid(winValid)
  );

  // {state, rx, col, chainIn, expected index, expected chainOut}
  localparam int NV = 13;
  localparam logic [20:0] VECS [NV] = '{
    {2'b00, 7'b0000000, 7'b0000000, 1'b1, 3'd0, 1'b1},  // R5 quiet idle
    {2'b00, 7'b0000100, 7'b0000000, 1'b1, 3'd3, 1'b0},  // R2 port 3 rx
    {2'b00, 7'b1000000, 7'b0000010, 1'b1, 3'd2, 1'b0},  // R2 collision counts
    {2'b00, 7'b1111111, 7'b0000000, 1'b1, 3'd1, 1'b0},  // R1 top port
    {2'b00, 7'b0010000, 7'b0000000, 1'b0, 3'd0, 1'b0},  // R4 chain off
    {2'b01, 7'b0000001, 7'b0100000, 1'b1, 3'd6, 1'b0},  // R3 col only
    {2'b01, 7'b1111111, 7'b0000000, 1'b1, 3'd0, 1'b1},  // R3 rx ignored
    {2'b00, 7'b1000000, 7'b0000000, 1'b1, 3'd7, 1'b0},  // R1 bottom port
    {2'b10, 7'b0000001, 7'b0000001, 1'b1, 3'd7, 1'b1},  // R6 hold
    {2'b10, 7'b0000001, 7'b0000000, 1'b0, 3'd7, 1'b0},  // R6 mirror low
    {2'b01, 7'b0000000, 7'b1101000, 1'b1, 3'd4, 1'b0},  // R1 collision pick
    {2'b11, 7'b0000001, 7'b0000001, 1'b1, 3'd4, 1'b1},  // R6 hold
    {2'b01, 7'b0000000, 7'b1000000, 1'b0, 3'd0, 1'b0}   // R4 chain off
  };

  function automatic string tagOf(int i);
    case (i)
      0: return "R5";
      1, 2: return "R2";
      3, 7, 10: return "R1";
      4, 12: return "R4";
      5, 6: return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #5;
    check("R8 idx", winIdx, 0);
    check("R8 valid", winValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {repState, rxAct, colAct, chainIn} = VECS[i][20:4];
      #2;
      check({tagOf(i), " chainOut"}, chainOut, VECS[i][0]);
      @(posedge clk);
      #5;
      check({tagOf(i), " idx"}, winIdx, VECS[i][3:1]);
      check("R7 valid", winValid, VECS[i][3:1] != 0);
    end
    // R7: one-cycle latency, value not visible before the edge
    @(negedge clk);
    repState = 2'b00; rxAct = 7'b0100000; colAct = '0; chainIn = 1'b1;
    #2;
    check("R7 before edge", winIdx, 0);
    @(posedge clk); #5;
    check("R7 after edge", winIdx, 6);
    // R8: reset clears a held winner
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #5;
    check("R8 idx cleared", winIdx, 0);
    check("R8 valid cleared", winValid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule